// File: doc/BRIEF.md
# Telecom bus receive checker

This block sits on the receive side of a byte-wide STS-3/STM-1 telecom bus. Each bus clock it takes one byte together with a payload-valid flag, a frame-phase marker, a parity bit and an alarm strobe. It verifies the parity of every byte against a selectable sense (even or odd) and a selectable coverage (data alone, or data plus the two control flags). Each mismatch is reported as a one-clock pulse and counted in a saturating counter.

The block also works out which of the three byte-interleaved STS-1 tributaries each byte belongs to, using the phase marker to find the start of a frame. An alarm strobe raises a path AIS defect for the tributary of the strobed byte. In concatenated mode it raises the defect for the whole signal. The defect is released once its tributary has gone three whole frames without a strobe. A bus-enable input gates the parity check and the alarm input together.

Top module: `tbus_rx_checker`

## Requirements
- R1: Once reset is released, and before any bus byte has been sampled, par_err, err_count, ais and trib_idx are all zero.
- R2: With par_wide=0, parity covers rx_data only. par_odd=0 expects the total count of ones in rx_data and rx_par to be even, and par_odd=1 expects it to be odd. A mismatch sampled at one rising edge shows par_err=1 for exactly the following clock cycle.
- R3: With par_wide=1, parity covers rx_data, rx_pv and rx_mark together with rx_par, using the same sense rule as R2.
- R4: While bus_en=0, no byte produces par_err, err_count does not change, and no ais bit is set.
- R5: Each parity error adds one to err_count in the same cycle that par_err is shown. The count stops at 65535.
- R6: cnt_clr=1 at an edge sets err_count to 0. This holds even when a parity error is sampled at the same edge.
- R7: A byte with rx_mark=1 and rx_pv=0 is frame start and belongs to tributary 0. The following bytes belong to tributaries 1, 2, 0, 1, ... in turn. trib_idx shows the tributary of the byte sampled at the previous edge.
- R8: With sts3c=0 and bus_en=1, rx_alarm=1 on a byte of tributary t sets ais bit t from the next cycle.
- R9: With sts3c=1 and bus_en=1, rx_alarm=1 on any byte sets all three ais bits from the next cycle.
- R10: A set ais bit t clears at the frame-start byte that closes the third consecutive full frame with no alarm for tributary t. An alarm on a frame-start byte counts for the frame that it opens.
- R11: A marker byte with rx_pv=1 (a J1 marker) does not restart the tributary sequence and is not a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus enable; when 0 the parity and alarm inputs are ignored |
| par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| par_wide | input | 1 | 1 adds rx_pv and rx_mark to the parity coverage |
| sts3c | input | 1 | 1 selects concatenated mode, in which one defect covers all tributaries |
| cnt_clr | input | 1 | Clears the error counter |
| rx_data | input | 8 | Bus data byte |
| rx_pv | input | 1 | Payload-valid flag |
| rx_mark | input | 1 | Frame-start / J1 phase marker |
| rx_par | input | 1 | Parity bit |
| rx_alarm | input | 1 | Byte-coincident path AIS strobe |
| par_err | output | 1 | One-cycle parity error pulse |
| err_count | output | 16 | Saturating parity error count |
| ais | output | 3 | Path AIS defect, bit t for tributary t |
| trib_idx | output | 2 | Tributary of the byte sampled at the previous edge |

## Verification
Two functions can act at the same edge. The error counter has to absorb a parity error while cnt_clr is asserted. The AIS tracker has to handle an alarm strobe that lands on a frame-start byte, so the frame close and the new strobe are processed together. Both cases are driven directly: a deliberately wrong parity bit together with the clear, and an alarm placed on the marker byte. In the first case the counter must read zero. In the second case the defect must stay set and its three-frame release must be counted from that frame. Random traffic with a fixed seed runs alongside these cases and is compared each cycle against a bench model that is built from the requirements.

// File: rtl/tbus_pkg.sv
package tbus_pkg;
  localparam int unsigned TB_DATA_W   = 8;
  localparam int unsigned TB_NUM_TRIB = 3;
  localparam int unsigned TB_CNT_W    = 16;
  localparam int unsigned TB_CLR_FRM  = 3;

  typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} par_sense_e;
endpackage

// File: rtl/tbus_par_chk.sv
module tbus_par_chk
  import tbus_pkg::*;
#(
  parameter int unsigned DATA_W = TB_DATA_W,
  parameter int unsigned CNT_W  = TB_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              par_odd,
  input  logic              par_wide,
  input  logic              cnt_clr,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_pv,
  input  logic              rx_mark,
  input  logic              rx_par,
  output logic              par_err,
  output logic [CNT_W-1:0]  err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             cover_x;
  logic             exp_par;
  logic             err_d;
  logic             err_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cover_x = ^rx_data;
    if (par_wide) cover_x = cover_x ^ rx_pv ^ rx_mark;
    exp_par = (par_sense_e'(par_odd) == PAR_ODD) ? ~cover_x : cover_x;
    err_d   = bus_en && (rx_par != exp_par);
    cnt_d   = cnt_q;
    if (cnt_clr)                        cnt_d = '0;
    else if (err_d && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      err_q <= err_d;
      cnt_q <= cnt_d;
    end
  end

  assign par_err   = err_q;
  assign err_count = cnt_q;

  assert_no_err_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> !par_err);
  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !cnt_clr) |=> err_count == CNT_MAX);
  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> err_count == '0);
endmodule

// File: rtl/tbus_trib_cnt.sv
module tbus_trib_cnt
  import tbus_pkg::*;
#(
  parameter int unsigned NUM_TRIB = TB_NUM_TRIB,
  localparam int unsigned TW = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_mark,
  input  logic          rx_pv,
  output logic          frame_start,
  output logic [TW-1:0] cur_trib,
  output logic [TW-1:0] trib_q
);
  localparam logic [TW-1:0] LAST = TW'(NUM_TRIB - 1);

  logic [TW-1:0] nxt_q;
  logic [TW-1:0] nxt_d;

  always_comb begin
    frame_start = rx_mark && !rx_pv;
    cur_trib    = frame_start ? '0 : nxt_q;
    nxt_d       = (cur_trib == LAST) ? '0 : cur_trib + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q  <= '0;
      trib_q <= '0;
    end else begin
      nxt_q  <= nxt_d;
      trib_q <= cur_trib;
    end
  end

  assert_frame_start_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mark && !rx_pv) |=> trib_q == '0);
  assert_trib_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trib_q <= LAST);
endmodule

// File: rtl/tbus_ais_trk.sv
module tbus_ais_trk
  import tbus_pkg::*;
#(
  parameter int unsigned CLR_FRM = TB_CLR_FRM,
  localparam int unsigned MW = $clog2(CLR_FRM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic frame_start,
  output logic ais
);
  localparam logic [MW-1:0] MISS_LAST = MW'(CLR_FRM - 1);

  logic          seen_q, seen_d;
  logic          ais_q, ais_d;
  logic [MW-1:0] miss_q, miss_d;

  always_comb begin
    seen_d = seen_q;
    ais_d  = ais_q;
    miss_d = miss_q;
    if (frame_start) begin
      seen_d = 1'b0;
      if (seen_q) begin
        miss_d = '0;
      end else if (ais_q) begin
        if (miss_q == MISS_LAST) begin
          ais_d  = 1'b0;
          miss_d = '0;
        end else begin
          miss_d = miss_q + 1'b1;
        end
      end
    end
    if (hit) begin
      seen_d = 1'b1;
      ais_d  = 1'b1;
      miss_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      ais_q  <= 1'b0;
      miss_q <= '0;
    end else begin
      seen_q <= seen_d;
      ais_q  <= ais_d;
      miss_q <= miss_d;
    end
  end

  assign ais = ais_q;

  assert_hit_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ais);
  assert_rise_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ais) |-> $past(hit));
  assert_fall_on_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ais) |-> $past(frame_start));
endmodule

// File: rtl/tbus_rx_checker.sv
module tbus_rx_checker
  import tbus_pkg::*;
#(
  parameter int unsigned DATA_W   = TB_DATA_W,
  parameter int unsigned NUM_TRIB = TB_NUM_TRIB,
  parameter int unsigned CNT_W    = TB_CNT_W,
  parameter int unsigned CLR_FRM  = TB_CLR_FRM,
  localparam int unsigned TW = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                par_odd,
  input  logic                par_wide,
  input  logic                sts3c,
  input  logic                cnt_clr,
  input  logic [DATA_W-1:0]   rx_data,
  input  logic                rx_pv,
  input  logic                rx_mark,
  input  logic                rx_par,
  input  logic                rx_alarm,
  output logic                par_err,
  output logic [CNT_W-1:0]    err_count,
  output logic [NUM_TRIB-1:0] ais,
  output logic [TW-1:0]       trib_idx
);
  logic          frame_start;
  logic [TW-1:0] cur_trib;
  logic          alarm_ok;

  assign alarm_ok = bus_en && rx_alarm;

  tbus_par_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_par (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .par_odd(par_odd),
    .par_wide(par_wide), .cnt_clr(cnt_clr), .rx_data(rx_data),
    .rx_pv(rx_pv), .rx_mark(rx_mark), .rx_par(rx_par),
    .par_err(par_err), .err_count(err_count)
  );

  tbus_trib_cnt #(.NUM_TRIB(NUM_TRIB)) u_trib (
    .clk(clk), .rst_n(rst_n), .rx_mark(rx_mark), .rx_pv(rx_pv),
    .frame_start(frame_start), .cur_trib(cur_trib), .trib_q(trib_idx)
  );

  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_trib
    logic hit_t;
    assign hit_t = alarm_ok && (sts3c || cur_trib == TW'(t));
    tbus_ais_trk #(.CLR_FRM(CLR_FRM)) u_ais (
      .clk(clk), .rst_n(rst_n), .hit(hit_t),
      .frame_start(frame_start), .ais(ais[t])
    );
  end

  assert_no_ais_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> (ais & ~$past(ais)) == '0);
  assert_concat_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts3c && alarm_ok) |=> &ais);
endmodule

// File: tb/sim_tbus_rx_checker.sv
`timescale 1ns/1ps
module sim_tbus_rx_checker;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_en, par_odd, par_wide, sts3c, cnt_clr;
  logic [7:0] rx_data;
  logic rx_pv, rx_mark, rx_par, rx_alarm;
  logic par_err;
  logic [15:0] err_count;
  logic [2:0] ais;
  logic [1:0] trib_idx;

  always #10 clk = ~clk; // 50 MHz

  tbus_rx_checker u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .par_odd(par_odd),
    .par_wide(par_wide), .sts3c(sts3c), .cnt_clr(cnt_clr),
    .rx_data(rx_data), .rx_pv(rx_pv), .rx_mark(rx_mark), .rx_par(rx_par),
    .rx_alarm(rx_alarm), .par_err(par_err), .err_count(err_count),
    .ais(ais), .trib_idx(trib_idx)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string phase = "R2";

  // bench model state
  int m_nxt = 0;
  int m_cnt = 0;
  bit m_err = 0;
  int m_trib = 0;
  bit [2:0] m_ais = '0;
  bit [2:0] m_seen = '0;
  int m_miss [3] = '{0, 0, 0};
  int pos = 0;

  function automatic bit good_par(bit [7:0] d, bit pv, bit mk, bit odd, bit wide);
    bit x = ^d;
    if (wide) x = x ^ pv ^ mk;
    return odd ? ~x : x;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit fs = rx_mark && !rx_pv;
    int cur = fs ? 0 : m_nxt;
    bit perr = bus_en && (rx_par != good_par(rx_data, rx_pv, rx_mark, par_odd, par_wide));
    m_nxt = (cur == 2) ? 0 : cur + 1;
    m_trib = cur;
    m_err = perr;
    if (cnt_clr) m_cnt = 0;
    else if (perr && m_cnt != 65535) m_cnt++;
    for (int t = 0; t < 3; t++) begin
      bit hit = bus_en && rx_alarm && (sts3c || cur == t);
      if (fs) begin
        if (m_seen[t]) m_miss[t] = 0;
        else if (m_ais[t]) begin
          if (m_miss[t] == 2) begin m_ais[t] = 0; m_miss[t] = 0; end
          else m_miss[t]++;
        end
        m_seen[t] = 0;
      end
      if (hit) begin m_seen[t] = 1; m_ais[t] = 1; m_miss[t] = 0; end
    end
  endtask

  task automatic step(bit full = 1);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk({phase, " par_err"}, par_err, m_err);
    chk({phase, " err_count R5"}, err_count, m_cnt);
    if (full) begin
      chk({phase, " trib_idx R7"}, trib_idx, m_trib);
      chk({phase, " ais R8/R10"}, ais, m_ais);
    end
  endtask

  // drive one byte of a frame of flen bytes; J1 marker with pv=1 at mid-frame
  task automatic drive_byte(int flen, bit j1, int bad_pct, int al_pct, int al_trib);
    rx_mark = (pos == 0) || (j1 && pos == flen / 2);
    rx_pv = (pos == 0) ? 1'b0 : (rx_mark ? 1'b1 : 1'($urandom_range(0, 1)));
    rx_data = 8'($urandom);
    rx_par = good_par(rx_data, rx_pv, rx_mark, par_odd, par_wide);
    if ($urandom_range(0, 99) < bad_pct) rx_par = ~rx_par;
    rx_alarm = ($urandom_range(0, 99) < al_pct) &&
               (al_trib < 0 || m_nxt_cur() == al_trib);
    pos = (pos == flen - 1) ? 0 : pos + 1;
  endtask

  function automatic int m_nxt_cur();
    return (rx_mark && !rx_pv) ? 0 : m_nxt;
  endfunction

  task automatic run(int n, int flen, bit j1, int bad_pct, int al_pct, int al_trib);
    for (int i = 0; i < n; i++) begin
      drive_byte(flen, j1, bad_pct, al_pct, al_trib);
      step();
    end
  endtask

  initial begin
    int unsigned seed = $urandom(32'h5eed_1234);
    rst_n = 1'b0;
    bus_en = 1'b1; par_odd = 1'b0; par_wide = 1'b0; sts3c = 1'b0; cnt_clr = 1'b0;
    rx_data = '0; rx_pv = 1'b0; rx_mark = 1'b0; rx_par = 1'b0; rx_alarm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 par_err", par_err, 0);
    chk("R1 err_count", err_count, 0);
    chk("R1 ais", ais, 0);
    chk("R1 trib_idx", trib_idx, 0);
    pos = 0;

    // R2: data-only coverage, even then odd
    phase = "R2 even"; run(300, 24, 0, 30, 0, -1);
    par_odd = 1'b1; phase = "R2 odd"; run(300, 24, 0, 30, 0, -1);
    // R3: wide coverage with control flags
    par_wide = 1'b1; phase = "R3 odd"; run(300, 24, 0, 30, 0, -1);
    par_odd = 1'b0; phase = "R3 even"; run(300, 24, 0, 30, 0, -1);
    // R7 / R11: J1 markers inside frames must not restart the sequence
    phase = "R11"; run(400, 30, 1, 10, 0, -1);
    // R8 and R10: alarms on single tributaries, then release after 3 frames
    phase = "R8 trib1"; run(60, 21, 1, 5, 20, 1);
    phase = "R10 quiet"; run(21 * 5, 21, 1, 5, 0, -1);
    phase = "R8 trib2"; run(60, 21, 1, 5, 20, 2);
    phase = "R10 quiet"; run(21 * 5, 21, 1, 5, 0, -1);
    // R10: alarm on the frame-start byte itself (counts for trib 0, new frame)
    while (pos != 0) begin drive_byte(21, 0, 0, 0, -1); step(); end
    phase = "R10 fs-alarm";
    drive_byte(21, 0, 0, 0, -1); rx_alarm = 1'b1; step();
    rx_alarm = 1'b0; run(21 * 4 - 1, 21, 0, 0, 0, -1);
    // R9: concatenated mode
    sts3c = 1'b1; phase = "R9"; run(120, 21, 1, 5, 3, -1);
    phase = "R10 s3c"; run(21 * 5, 21, 1, 5, 0, -1);
    sts3c = 1'b0;
    // R4: bus disabled, bad parity and alarms everywhere
    bus_en = 1'b0; phase = "R4"; run(200, 24, 1, 80, 50, -1);
    bus_en = 1'b1;
    // R6: clear coinciding with a parity error
    phase = "R6 clr+err";
    drive_byte(24, 0, 100, 0, -1); cnt_clr = 1'b1; step();
    chk("R6 cleared with err", err_count, 0);
    cnt_clr = 1'b0;
    phase = "R6 after"; run(50, 24, 0, 50, 0, -1);
    // mixed random
    phase = "mix"; run(1500, 27, 1, 20, 2, -1);
    // R5: saturation
    phase = "R5 sat";
    for (int i = 0; i < 65600; i++) begin
      drive_byte(24, 0, 100, 0, -1);
      step(0);
    end
    chk("R5 saturated", err_count, 65535);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule